// File: doc/BRIEF.md
# Multi-Source Wake-Up Controller

This block decides when a sleeping system should be woken. It watches three general-purpose pins, a push-button pin, the serial-receive pin and a programmable countdown timer. When a source that software has enabled meets its wake condition, the block latches a sticky flag for that source. It raises a wake request to the power manager whenever the system is in a low-power mode and at least one flag is set.

Some sources wake on a rising edge and others on a high level. The push-button is accepted only after a long sampled qualification on a slow tick. The countdown timer is armed and loaded by software, and it counts only while the system sleeps or shows its display only. Three reset causes are recorded without any enable: watchdog overflow, cold start and low backup-battery voltage.

Software reaches the enables, the reload value and the flags through a small register port. The write strobe is registered. The read data is combinational from the address.

Top module: `wakeup_ctrl`

## Requirements
- R1: After reset the enable register (address 0) and the flag register (address 2) read 0, the timer is disarmed, and `wake_req` is 0.
- R2: Flag bit 0 (general pin 0) and flag bit 4 (serial receive) are edge sources. Each sets on a 0-to-1 change of its pin and does not set again while the pin only stays high.
- R3: Flag bits 1 and 2 (general pins 1 and 2) and flag bit 3 (push-button) are level sources. Each sets in every cycle in which its qualified input is high.
- R4: A pin flag is forced to 0 while its enable bit (same bit position in address 0) is 0, or while its pin is not marked as a digital input. The push-button always counts as a digital input.
- R5: The push-button is sampled on each `tick`. It is accepted as high only after 32 consecutive high samples (64 ms at a 2 ms tick). Any low sample restarts the count.
- R6: Writing 1 to bit 5 of address 0 loads the countdown from the reload register (address 1) and arms it. Writing 0 to that bit disarms it. The count steps once per `tick` only while `lowpwr_mode` is 1, and bit 5 of address 0 reads back the armed state.
- R7: The timer fires on the tick that brings the count to zero: the R-th tick for a reload value R of 1 or more, and the first tick for a reload value of 0. Firing sets flag bit 5 and disarms the timer.
- R8: Cause bits in address 3 (bit 0 watchdog, bit 1 cold start, bit 2 low battery) take the cause inputs while reset is held. A later high cause input sets its bit at once with no debounce. Writing 1 to a bit clears it.
- R9: `wake_req` is 1 exactly when `lowpwr_mode` is 1 and any flag or cause bit is set. It stays 0 in normal run mode.
- R10: Flags stay set until a write of 1 to their bit in address 2. A wake condition present in the same cycle as that write keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 enables/arm, 1 reload, 2 flags, 3 causes) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| gp_pins | input | 3 | General pins: bit 0 edge source, bits 1-2 level sources |
| gp_is_input | input | 3 | Per general pin: configured as digital input |
| btn_in | input | 1 | Push-button pin (debounced level source) |
| rx_in | input | 1 | Serial-receive pin (edge source) |
| rx_is_input | input | 1 | Serial-receive pin configured as digital input |
| lowpwr_mode | input | 1 | System is in sleep or display-only mode |
| tick | input | 1 | One-cycle pulse of the slow sample tick |
| cause_wdt | input | 1 | Watchdog overflow reset cause |
| cause_cold | input | 1 | Cold-start reset cause |
| cause_lowbat | input | 1 | Low backup-battery reset cause |
| wake_req | output | 1 | Wake request to the power manager |

## Verification
The bench builds the block with its defaults: an 8-bit register port, an 8-bit countdown, a two-stage input synchronizer, and a 2 ms tick against a 64 ms qualification window. With these values the full 32-sample button window and its restart on a single low sample fit in a few hundred cycles. The same holds for a 3-tick countdown and the zero-reload corner. Random enable, input-mode and pin patterns are checked against a bench model of edge and level flags, before and after a clear write.

// File: rtl/wake_pkg.sv
package wake_pkg;
   localparam int NPIN     = 5;
   localparam int NFLAG    = 6;
   localparam int NCAUSE   = 3;
   localparam int SRC_GPE  = 0;
   localparam int SRC_LV0  = 1;
   localparam int SRC_LV1  = 2;
   localparam int SRC_BTN  = 3;
   localparam int SRC_RX   = 4;
   localparam int SRC_TMR  = 5;
   localparam int ARM_BIT  = 5;
   localparam logic [NPIN-1:0] EDGE_SRCS = 5'b10001;

   typedef enum logic [1:0] {
      A_ENABLE = 2'd0,
      A_RELOAD = 2'd1,
      A_FLAGS  = 2'd2,
      A_CAUSE  = 2'd3
   } wake_addr_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) st[k] <= '0;
            end else begin
               st[0] <= d;
               for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= q;
   end

   assign rise = q & ~prev_q;
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce #(
   parameter int SAMPLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic level,
   output logic ok
);
   localparam int CW = $clog2(SAMPLES + 1);
   localparam logic [CW-1:0] FULL = CW'(SAMPLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         if (!level)          cnt <= '0;
         else if (cnt != FULL) cnt <= cnt + 1'b1;
      end
   end

   assign ok = (cnt == FULL);
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         disarm,
   input  logic [W-1:0] reload,
   input  logic         step,
   output logic         armed,
   output logic [W-1:0] count,
   output logic         fire
);
   assign fire = armed & step & (count <= W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         count <= '0;
      end else if (load) begin
         armed <= 1'b1;
         count <= reload;
      end else if (disarm) begin
         armed <= 1'b0;
      end else if (fire) begin
         armed <= 1'b0;
         count <= '0;
      end else if (armed && step) begin
         count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/wakeup_ctrl.sv
module wakeup_ctrl
   import wake_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TMR_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TICK_MS     = 2,
   parameter int DEBOUNCE_MS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [2:0]        gp_pins,
   input  logic [2:0]        gp_is_input,
   input  logic              btn_in,
   input  logic              rx_in,
   input  logic              rx_is_input,
   input  logic              lowpwr_mode,
   input  logic              tick,
   input  logic              cause_wdt,
   input  logic              cause_cold,
   input  logic              cause_lowbat,
   output logic              wake_req
);
   localparam int DB_SAMPLES = DEBOUNCE_MS / TICK_MS;

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("wakeup_ctrl: DATA_W must be at least 8");
      end
      if (TMR_W < 1 || TMR_W > DATA_W) begin : g_bad_tmr_w
         $error("wakeup_ctrl: TMR_W must lie in 1..DATA_W");
      end
      if (TICK_MS < 1 || DEBOUNCE_MS % TICK_MS != 0 || DB_SAMPLES < 1) begin : g_bad_db
         $error("wakeup_ctrl: DEBOUNCE_MS must be a positive multiple of TICK_MS");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("wakeup_ctrl: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [NPIN-1:0]   raw_pins, pin_s, pin_rise, is_in, en_q, eff_en, hit;
   logic [NFLAG-1:0]  flags_q;
   logic [NCAUSE-1:0] cause_q, cause_in;
   logic [TMR_W-1:0]  reload_q, tmr_cnt;
   logic              armed, tmr_fire, db_ok;
   logic              wr_en, wr_flags, wr_cause, wr_reload;

   assign raw_pins = {rx_in, btn_in, gp_pins};
   assign is_in    = {rx_is_input, 1'b1, gp_is_input};
   assign eff_en   = en_q & is_in;
   assign cause_in = {cause_lowbat, cause_cold, cause_wdt};

   assign wr_en     = reg_we && (reg_addr == A_ENABLE);
   assign wr_reload = reg_we && (reg_addr == A_RELOAD);
   assign wr_flags  = reg_we && (reg_addr == A_FLAGS);
   assign wr_cause  = reg_we && (reg_addr == A_CAUSE);

   wake_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_pins),
      .q    (pin_s),
      .rise (pin_rise)
   );

   wake_debounce #(.SAMPLES(DB_SAMPLES)) u_db (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .level(pin_s[SRC_BTN]),
      .ok   (db_ok)
   );

   wake_timer #(.W(TMR_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_en && reg_wdata[ARM_BIT]),
      .disarm(wr_en && !reg_wdata[ARM_BIT]),
      .reload(reload_q),
      .step  (tick && lowpwr_mode),
      .armed (armed),
      .count (tmr_cnt),
      .fire  (tmr_fire)
   );

   // per-source wake condition: edge, debounced level or plain level
   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_hit
         if (EDGE_SRCS[i]) begin : g_edge
            assign hit[i] = pin_rise[i];
         end else if (i == SRC_BTN) begin : g_db
            assign hit[i] = db_ok;
         end else begin : g_lvl
            assign hit[i] = pin_s[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         reload_q <= '0;
      end else begin
         if (wr_en)     en_q     <= reg_wdata[NPIN-1:0];
         if (wr_reload) reload_q <= reg_wdata[TMR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else begin
         for (int i = 0; i < NPIN; i++) begin
            if (!eff_en[i])                    flags_q[i] <= 1'b0;
            else if (hit[i])                   flags_q[i] <= 1'b1;
            else if (wr_flags && reg_wdata[i]) flags_q[i] <= 1'b0;
         end
         if (tmr_fire)                              flags_q[SRC_TMR] <= 1'b1;
         else if (wr_flags && reg_wdata[SRC_TMR])   flags_q[SRC_TMR] <= 1'b0;
      end
   end

   // cause bits follow the cause inputs while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= cause_in;
      else        cause_q <= (cause_q & ~(wr_cause ? reg_wdata[NCAUSE-1:0] : '0)) | cause_in;
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_ENABLE: begin
            reg_rdata[NPIN-1:0] = en_q;
            reg_rdata[ARM_BIT]  = armed;
         end
         A_RELOAD: reg_rdata[TMR_W-1:0]  = reload_q;
         A_FLAGS:  reg_rdata[NFLAG-1:0]  = flags_q;
         A_CAUSE:  reg_rdata[NCAUSE-1:0] = cause_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign wake_req = lowpwr_mode && ((|flags_q) || (|cause_q));
endmodule

// File: rtl/wakeup_ctrl_chk.sv
module wakeup_ctrl_chk
   import wake_pkg::*;
#(
   parameter int TMR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic             lowpwr_mode,
   input logic             tick,
   input logic             wake_req,
   input logic [NPIN-1:0]  eff_en,
   input logic [NPIN-1:0]  pin_s,
   input logic [NFLAG-1:0] flags_q,
   input logic             armed,
   input logic [TMR_W-1:0] tmr_cnt,
   input logic             tmr_fire,
   input logic             db_ok
);
   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_pin
         // R4: a source that is not enabled as a digital input keeps its flag clear
         p_disabled_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !eff_en[i] |=> !flags_q[i]);
         // R10: a set flag survives any cycle without a register write
         p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            flags_q[i] && eff_en[i] && !reg_we |=> flags_q[i]);
      end
   endgenerate

   p_run_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lowpwr_mode |-> !wake_req);

   p_hold_outside_lp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !lowpwr_mode && !reg_we |=> $stable(tmr_cnt) && armed);

   p_fire_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_fire && !reg_we |=> flags_q[SRC_TMR] && !armed);

   p_db_qualify_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(db_ok) |-> $past(tick && pin_s[SRC_BTN]));
endmodule

bind wakeup_ctrl wakeup_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .lowpwr_mode(lowpwr_mode),
   .tick       (tick),
   .wake_req   (wake_req),
   .eff_en     (eff_en),
   .pin_s      (pin_s),
   .flags_q    (flags_q),
   .armed      (armed),
   .tmr_cnt    (tmr_cnt),
   .tmr_fire   (tmr_fire),
   .db_ok      (db_ok)
);

// File: tb/wakeup_ctrl_test.sv
module wakeup_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [2:0] gp_pins = '0;
   logic [2:0] gp_is_input = '0;
   logic       btn_in = 1'b0;
   logic       rx_in = 1'b0;
   logic       rx_is_input = 1'b0;
   logic       lowpwr_mode = 1'b0;
   logic       tick = 1'b0;
   logic       cause_wdt = 1'b0;
   logic       cause_cold = 1'b0;
   logic       cause_lowbat = 1'b0;
   logic       wake_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wakeup_ctrl uut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   // expected pin flags: edge bits 0/4 on rise, level bits 1/2 on high seen
   function automatic logic [7:0] exp_flags(input logic [4:0] en, input logic [4:0] isin,
                                            input logic [4:0] oldp, input logic [4:0] newp,
                                            input bit after_clear);
      logic [4:0] eff, f;
      eff = en & isin;
      f = '0;
      f[0] = after_clear ? 1'b0 : (newp[0] & ~oldp[0]);
      f[4] = after_clear ? 1'b0 : (newp[4] & ~oldp[4]);
      f[1] = after_clear ? newp[1] : (newp[1] | oldp[1]);
      f[2] = after_clear ? newp[2] : (newp[2] | oldp[2]);
      return {3'b000, f & eff};
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'h5EED_0042));
      cause_cold = 1'b1;
      cycles(4);
      rst_n = 1'b1; cause_cold = 1'b0;
      cycles(2);

      // R1 reset state, R8 cause taken during reset
      rd(2'd0, v); check("R1 enable reg", v, 8'h00);
      rd(2'd2, v); check("R1 flag reg", v, 8'h00);
      check("R1 wake_req", wake_req, 1'b0);
      rd(2'd3, v); check("R8 cold cause after reset", v, 8'h02);

      // R8 pulse, R9 wake from cause, clear
      @(negedge clk); cause_wdt = 1'b1;
      @(negedge clk); cause_wdt = 1'b0;
      rd(2'd3, v); check("R8 watchdog sets at once", v, 8'h03);
      lowpwr_mode = 1'b1; #1;
      check("R9 wake on cause in low power", wake_req, 1'b1);
      lowpwr_mode = 1'b0; #1;
      check("R9 quiet in run mode", wake_req, 1'b0);
      wr(2'd3, 8'h01);
      rd(2'd3, v); check("R8 write-1 clears one bit", v, 8'h02);
      wr(2'd3, 8'h07);
      rd(2'd3, v); check("R8 all cleared", v, 8'h00);

      // R2 directed: edge pin stays clear while held high after clear
      gp_is_input = 3'b001;
      wr(2'd0, 8'h01);
      @(negedge clk); gp_pins[0] = 1'b1;
      cycles(5);
      rd(2'd2, v); check("R2 edge pin sets on rise", v, 8'h01);
      wr(2'd2, 8'h01);
      cycles(5);
      rd(2'd2, v); check("R2 no re-set on static high", v, 8'h00);
      gp_pins = '0;

      // R2 R3 R4 R10 random patterns
      for (int it = 0; it < 40; it++) begin
         logic [4:0] en, isin, oldp, newp;
         en   = 5'($urandom) & 5'b10111;
         isin = 5'($urandom) | 5'b01000;
         oldp = 5'($urandom) & 5'b10111;
         newp = 5'($urandom) & 5'b10111;
         wr(2'd0, 8'h00);
         @(negedge clk);
         gp_is_input = {isin[2], isin[1], isin[0]}; rx_is_input = isin[4];
         gp_pins = oldp[2:0]; rx_in = oldp[4];
         cycles(5);
         wr(2'd0, {3'b000, en});
         @(negedge clk);
         gp_pins = newp[2:0]; rx_in = newp[4];
         cycles(6);
         rd(2'd2, v);
         check("R2 R3 R4 random flags", v, exp_flags(en, isin, oldp, newp, 1'b0));
         wr(2'd2, 8'h3F);
         cycles(2);
         rd(2'd2, v);
         check("R10 R3 flags after clear", v, exp_flags(en, isin, oldp, newp, 1'b1));
      end
      wr(2'd0, 8'h00);
      gp_pins = '0; rx_in = 1'b0; gp_is_input = '0; rx_is_input = 1'b0;
      cycles(3);

      // R5 debounce, R4 button always an input
      wr(2'd0, 8'h08);
      @(negedge clk); btn_in = 1'b1;
      cycles(4);
      ticks(31);
      cycles(2);
      rd(2'd2, v); check("R5 31 samples not enough", v, 8'h00);
      btn_in = 1'b0; cycles(4);
      ticks(1);
      btn_in = 1'b1; cycles(4);
      ticks(31);
      cycles(2);
      rd(2'd2, v); check("R5 low sample restarts count", v, 8'h00);
      ticks(1);
      cycles(2);
      rd(2'd2, v); check("R5 R4 32nd sample accepts button", v, 8'h08);
      wr(2'd0, 8'h00);
      cycles(2);
      rd(2'd2, v); check("R4 disable clears flag", v, 8'h00);
      btn_in = 1'b0;
      ticks(1);

      // R6 R7 timer
      wr(2'd1, 8'd3);
      wr(2'd0, 8'h20);
      ticks(5);
      rd(2'd0, v); check("R6 armed, no count in run mode", v, 8'h20);
      rd(2'd2, v); check("R6 no fire in run mode", v, 8'h00);
      lowpwr_mode = 1'b1;
      ticks(2);
      cycles(1);
      rd(2'd2, v); check("R7 no fire before zero", v, 8'h00);
      check("R9 no wake without flag", wake_req, 1'b0);
      ticks(1);
      cycles(1);
      rd(2'd2, v); check("R7 fires on third tick", v, 8'h20);
      rd(2'd0, v); check("R7 disarmed after fire", v, 8'h00);
      check("R9 wake in low power", wake_req, 1'b1);
      lowpwr_mode = 1'b0; #1;
      check("R9 suppressed in run mode", wake_req, 1'b0);
      wr(2'd2, 8'h20);
      rd(2'd2, v); check("R10 timer flag cleared", v, 8'h00);

      // R7 zero reload fires on first tick
      wr(2'd1, 8'd0);
      wr(2'd0, 8'h20);
      lowpwr_mode = 1'b1;
      ticks(1);
      cycles(1);
      rd(2'd2, v); check("R7 zero reload first tick", v, 8'h20);

      // R6 disarm by write of 0
      wr(2'd2, 8'h20);
      wr(2'd1, 8'd2);
      wr(2'd0, 8'h20);
      wr(2'd0, 8'h00);
      ticks(4);
      rd(2'd2, v); check("R6 disarmed timer never fires", v, 8'h00);
      lowpwr_mode = 1'b0;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule